// File: doc/BRIEF.md
# Serial Programming Command Access Guard

This block decides whether a command that a serial programming handler has already decoded may run. Each command arrives as a one-cycle strobe with an operation code, a start address, a byte count and a first and last sector number. One clock later the guard answers with a pulse that carries an allow bit and a return code. The answer depends on three things: the protection level the chip came out of reset with, whether the current session has been unlocked, and format rules on the address, count and sector fields. Text parsing and the actual execution of the command stay with the handler.

The protection level comes from a 32-bit word. The guard samples that word once, in the first cycle after reset is released, and maps a small set of magic values onto levels. Levels one and two forbid certain operations outright and restrict others by address or by sector range. Every other value of the word means no protection. The session unlock flag is set by an unlock command that carries the right key. It stays set until the next reset. It gates the flash-modifying commands and the go command.

Top module: `cmd_access_guard`

## Requirements
- R1: The guard samples `prot_word` only at the first rising edge after `rst_n` goes high, and drives the result on `level_o`: 0x12345678 gives 1, 0x87654321 gives 2, 0x43218765 gives 3, 0x4E697370 gives 4, and any other value gives 0. Later changes of `prot_word` do not change `level_o`.
- R2: When `cmd_valid` is high at a rising edge, `resp_valid` is high for exactly the next cycle, and is otherwise low. `resp_allow` is 1 exactly when `resp_code` is 0 (success).
- R3: Operation codes are 1 unlock, 2 write-RAM, 3 read-memory, 4 prepare, 5 copy-to-flash, 6 erase, 7 go, 8 compare and 9 echo. Any other code returns 1 (invalid command).
- R4: At level 1, read-memory and compare return 4 (protected). Write-RAM to an address below 0x10000600 returns 4. Copy-to-flash whose destination address `cmd_addr[31:10]` lies in sector 0 returns 4.
- R5: At level 1, an erase whose range starts at sector 0 returns 4 unless it runs from 0 to the last sector (63). Erases that do not touch sector 0 are not restricted by protection.
- R6: At level 2, read-memory, write-RAM, go, copy-to-flash and compare return 4. Erase returns 4 unless the range is exactly 0 to 63.
- R7: Levels 0, 3 and 4 place no restriction on any command.
- R8: Write-RAM, read-memory, copy-to-flash and compare return 2 (address error) when `cmd_addr[1:0]` is not 0. Otherwise they return 3 (count error) when `cmd_count[1:0]` is not 0.
- R9: Copy-to-flash, erase and go return 5 (locked) while `unlocked_o` is 0.
- R10: An unlock command whose `cmd_addr` equals the key 23130 returns 0 and sets `unlocked_o` from the next cycle on. A wrong key returns 7 (parameter error) and leaves the flag unchanged. Once set, the flag stays set until reset.
- R11: Prepare and erase return 6 (invalid sector) when `sec_first` > `sec_last` or when `sec_last` > 63.
- R12: When several rules apply, the code is chosen in this order: invalid command, protected, locked, address error, count error, invalid sector, parameter error.
- R13: While reset is held, and right after it is released, `resp_valid`, `resp_allow`, `resp_code`, `unlocked_o` and `level_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prot_word | input | 32 | Protection word, sampled once after reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_code | input | 4 | Operation code |
| cmd_addr | input | 32 | Start address, or the key for unlock |
| cmd_count | input | 32 | Byte count |
| sec_first | input | 8 | First sector of the range |
| sec_last | input | 8 | Last sector of the range |
| resp_valid | output | 1 | Response strobe, one cycle after the command |
| resp_allow | output | 1 | Command may execute |
| resp_code | output | 4 | Return code |
| level_o | output | 3 | Latched protection level |
| unlocked_o | output | 1 | Session unlock flag |

## Verification
The bench runs one session for each protection word: all four magic values, plus random words that must read as unprotected. Within each session it sends random commands that mix operation codes, addresses around the RAM floor and inside sector 0, misaligned addresses and counts, and sector ranges that are full, partial, reversed or out of range. Comparing the sessions shows which denials come from the level and which come from the format rules. Directed sequences then cover the following cases:
- a gated command sent before and after a good unlock, which separates the lock from protection;
- a wrong key, which must leave the flag clear;
- inputs that break several rules at once, which expose the priority order;
- a change of the protection word after it has been latched, which must not change the level.

// File: rtl/cmd_access_pkg.sv
package cmd_access_pkg;

   typedef enum logic [2:0] {
      LVL_NONE    = 3'd0,
      LVL_ONE     = 3'd1,
      LVL_TWO     = 3'd2,
      LVL_THREE   = 3'd3,
      LVL_NOENTRY = 3'd4
   } lvl_e;

   localparam logic [31:0] MAGIC_ONE     = 32'h1234_5678;
   localparam logic [31:0] MAGIC_TWO     = 32'h8765_4321;
   localparam logic [31:0] MAGIC_THREE   = 32'h4321_8765;
   localparam logic [31:0] MAGIC_NOENTRY = 32'h4E69_7370;

   localparam int OPC_W = 4;
   localparam logic [OPC_W-1:0] OP_UNLOCK  = 4'd1;
   localparam logic [OPC_W-1:0] OP_WR_RAM  = 4'd2;
   localparam logic [OPC_W-1:0] OP_RD_MEM  = 4'd3;
   localparam logic [OPC_W-1:0] OP_PREPARE = 4'd4;
   localparam logic [OPC_W-1:0] OP_COPY    = 4'd5;
   localparam logic [OPC_W-1:0] OP_ERASE   = 4'd6;
   localparam logic [OPC_W-1:0] OP_GO      = 4'd7;
   localparam logic [OPC_W-1:0] OP_COMPARE = 4'd8;
   localparam logic [OPC_W-1:0] OP_ECHO    = 4'd9;

   localparam int RC_W = 4;
   localparam logic [RC_W-1:0] RC_OK      = 4'd0;
   localparam logic [RC_W-1:0] RC_BAD_OP  = 4'd1;
   localparam logic [RC_W-1:0] RC_ADDR    = 4'd2;
   localparam logic [RC_W-1:0] RC_COUNT   = 4'd3;
   localparam logic [RC_W-1:0] RC_PROT    = 4'd4;
   localparam logic [RC_W-1:0] RC_LOCKED  = 4'd5;
   localparam logic [RC_W-1:0] RC_SECTOR  = 4'd6;
   localparam logic [RC_W-1:0] RC_PARAM   = 4'd7;

   function automatic lvl_e word_to_level(input logic [31:0] w);
      lvl_e l;
      case (w)
         MAGIC_ONE:     l = LVL_ONE;
         MAGIC_TWO:     l = LVL_TWO;
         MAGIC_THREE:   l = LVL_THREE;
         MAGIC_NOENTRY: l = LVL_NOENTRY;
         default:       l = LVL_NONE;
      endcase
      return l;
   endfunction

endpackage

// File: rtl/prot_level_latch.sv
module prot_level_latch
   import cmd_access_pkg::*;
#(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] word_i,
   output lvl_e              level_o
);

   if (WORD_W != 32) begin : g_bad_width
      $error("prot_level_latch: protection word must be 32 bits");
   end

   logic armed_q;
   lvl_e level_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         level_q <= LVL_NONE;
      end else if (!armed_q) begin
         armed_q <= 1'b1;
         level_q <= word_to_level(word_i);
      end
   end

   assign level_o = level_q;

endmodule

// File: rtl/session_gate.sv
module session_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   output logic open_o
);

   logic open_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         open_q <= 1'b0;
      else if (set_i)
         open_q <= 1'b1;
   end

   assign open_o = open_q;

endmodule

// File: rtl/access_rules.sv
module access_rules
   import cmd_access_pkg::*;
#(
   parameter int          ADDR_W      = 32,
   parameter int          CNT_W       = 32,
   parameter int          SEC_W       = 8,
   parameter int          NUM_SECTORS = 64,
   parameter int          SECTOR_BYTES = 1024,
   parameter int          WORD_BYTES  = 4,
   parameter logic [31:0] RAM_FLOOR   = 32'h1000_0600,
   parameter logic [31:0] UNLOCK_KEY  = 32'd23130
) (
   input  lvl_e              level_i,
   input  logic              unlocked_i,
   input  logic [OPC_W-1:0]  op_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [CNT_W-1:0]  count_i,
   input  logic [SEC_W-1:0]  sec_first_i,
   input  logic [SEC_W-1:0]  sec_last_i,
   output logic [RC_W-1:0]   code_o,
   output logic              key_hit_o
);

   localparam int SEC_SHIFT  = $clog2(SECTOR_BYTES);
   localparam int ALIGN_BITS = $clog2(WORD_BYTES);
   localparam logic [SEC_W-1:0] LAST_SEC = SEC_W'(NUM_SECTORS - 1);

   if ((1 << SEC_SHIFT) != SECTOR_BYTES) begin : g_bad_sector
      $error("access_rules: sector size must be a power of two");
   end
   if ((1 << ALIGN_BITS) != WORD_BYTES) begin : g_bad_word
      $error("access_rules: word size must be a power of two");
   end
   if (NUM_SECTORS > (1 << SEC_W) || NUM_SECTORS < 1) begin : g_bad_count
      $error("access_rules: sector count does not fit the sector field");
   end
   if (SEC_SHIFT >= ADDR_W) begin : g_bad_addr
      $error("access_rules: address narrower than one sector");
   end

   // alignment checks, variant chosen by word size
   logic addr_aligned, count_whole;
   if (ALIGN_BITS == 0) begin : g_no_align
      assign addr_aligned = 1'b1;
      assign count_whole  = 1'b1;
   end else begin : g_align
      assign addr_aligned = (addr_i[ALIGN_BITS-1:0] == '0);
      assign count_whole  = (count_i[ALIGN_BITS-1:0] == '0);
   end

   // operation classes
   logic known_op, fmt_op, sec_op, gated_op;
   always_comb begin
      known_op = (op_i >= OP_UNLOCK) && (op_i <= OP_ECHO);
      fmt_op   = (op_i == OP_WR_RAM) || (op_i == OP_RD_MEM) ||
                 (op_i == OP_COPY)   || (op_i == OP_COMPARE);
      sec_op   = (op_i == OP_PREPARE) || (op_i == OP_ERASE);
      gated_op = (op_i == OP_COPY) || (op_i == OP_ERASE) || (op_i == OP_GO);
   end

   // range facts
   logic full_range, hits_sec0, below_floor, dest_sec0, range_ok;
   always_comb begin
      full_range  = (sec_first_i == '0) && (sec_last_i == LAST_SEC);
      hits_sec0   = (sec_first_i == '0);
      below_floor = (ADDR_W'(addr_i) < ADDR_W'(RAM_FLOOR));
      dest_sec0   = (addr_i[ADDR_W-1:SEC_SHIFT] == '0);
      range_ok    = (sec_first_i <= sec_last_i) && (sec_last_i <= LAST_SEC);
   end

   // protection by level
   logic prot_block;
   always_comb begin
      prot_block = 1'b0;
      unique case (level_i)
         LVL_ONE: begin
            prot_block = (op_i == OP_RD_MEM) || (op_i == OP_COMPARE) ||
                         ((op_i == OP_WR_RAM) && below_floor) ||
                         ((op_i == OP_COPY) && dest_sec0) ||
                         ((op_i == OP_ERASE) && hits_sec0 && !full_range);
         end
         LVL_TWO: begin
            prot_block = (op_i == OP_RD_MEM) || (op_i == OP_WR_RAM) ||
                         (op_i == OP_GO) || (op_i == OP_COPY) ||
                         (op_i == OP_COMPARE) ||
                         ((op_i == OP_ERASE) && !full_range);
         end
         default: prot_block = 1'b0;
      endcase
   end

   assign key_hit_o = (op_i == OP_UNLOCK) && (addr_i == ADDR_W'(UNLOCK_KEY));

   // verdict in fixed priority order
   always_comb begin
      if (!known_op)                       code_o = RC_BAD_OP;
      else if (prot_block)                 code_o = RC_PROT;
      else if (gated_op && !unlocked_i)    code_o = RC_LOCKED;
      else if (fmt_op && !addr_aligned)    code_o = RC_ADDR;
      else if (fmt_op && !count_whole)     code_o = RC_COUNT;
      else if (sec_op && !range_ok)        code_o = RC_SECTOR;
      else if ((op_i == OP_UNLOCK) && !key_hit_o) code_o = RC_PARAM;
      else                                 code_o = RC_OK;
   end

endmodule

// File: rtl/cmd_access_guard.sv
module cmd_access_guard
   import cmd_access_pkg::*;
#(
   parameter int          ADDR_W       = 32,
   parameter int          CNT_W        = 32,
   parameter int          SEC_W        = 8,
   parameter int          NUM_SECTORS  = 64,
   parameter int          SECTOR_BYTES = 1024,
   parameter int          WORD_BYTES   = 4,
   parameter logic [31:0] RAM_FLOOR    = 32'h1000_0600,
   parameter logic [31:0] UNLOCK_KEY   = 32'd23130
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [31:0]       prot_word,
   input  logic              cmd_valid,
   input  logic [3:0]        cmd_code,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [CNT_W-1:0]  cmd_count,
   input  logic [SEC_W-1:0]  sec_first,
   input  logic [SEC_W-1:0]  sec_last,
   output logic              resp_valid,
   output logic              resp_allow,
   output logic [3:0]        resp_code,
   output logic [2:0]        level_o,
   output logic              unlocked_o
);

   lvl_e            level;
   logic            unlocked;
   logic [RC_W-1:0] verdict;
   logic            key_hit;

   prot_level_latch #(.WORD_W(32)) u_level (
      .clk     (clk),
      .rst_n   (rst_n),
      .word_i  (prot_word),
      .level_o (level)
   );

   access_rules #(
      .ADDR_W      (ADDR_W),
      .CNT_W       (CNT_W),
      .SEC_W       (SEC_W),
      .NUM_SECTORS (NUM_SECTORS),
      .SECTOR_BYTES(SECTOR_BYTES),
      .WORD_BYTES  (WORD_BYTES),
      .RAM_FLOOR   (RAM_FLOOR),
      .UNLOCK_KEY  (UNLOCK_KEY)
   ) u_rules (
      .level_i     (level),
      .unlocked_i  (unlocked),
      .op_i        (cmd_code),
      .addr_i      (cmd_addr),
      .count_i     (cmd_count),
      .sec_first_i (sec_first),
      .sec_last_i  (sec_last),
      .code_o      (verdict),
      .key_hit_o   (key_hit)
   );

   session_gate u_gate (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (cmd_valid && key_hit),
      .open_o (unlocked)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         resp_valid <= 1'b0;
         resp_allow <= 1'b0;
         resp_code  <= RC_OK;
      end else begin
         resp_valid <= cmd_valid;
         if (cmd_valid) begin
            resp_code  <= verdict;
            resp_allow <= (verdict == RC_OK);
         end
      end
   end

   assign level_o    = level;
   assign unlocked_o = unlocked;

endmodule

// File: rtl/cmd_access_guard_sva.sv
module cmd_access_guard_sva (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_valid,
   input logic [3:0] cmd_code,
   input logic       resp_valid,
   input logic       resp_allow,
   input logic [3:0] resp_code,
   input logic [2:0] level_o,
   input logic       unlocked_o
);

   logic [1:0] cyc;
   always_ff @(posedge clk) begin
      if (!rst_n)          cyc <= 2'd0;
      else if (cyc != 2'd2) cyc <= cyc + 2'd1;
   end

   assert_resp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> resp_valid);

   assert_resp_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> !resp_valid);

   assert_allow_matches_R2: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> (resp_allow == (resp_code == 4'd0)));

   assert_level_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc == 2'd2) |-> $stable(level_o));

   assert_gate_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !unlocked_o && (cmd_code == 4'd5 || cmd_code == 4'd6 || cmd_code == 4'd7))
      |=> !resp_allow);

   assert_unlock_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      unlocked_o |=> unlocked_o);

   assert_l2_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_code == 4'd3 && level_o == 3'd2) |=> (resp_code == 4'd4));

   assert_bad_op_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && (cmd_code == 4'd0 || cmd_code > 4'd9)) |=> (resp_code == 4'd1));

endmodule

bind cmd_access_guard cmd_access_guard_sva u_sva (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_valid  (cmd_valid),
   .cmd_code   (cmd_code),
   .resp_valid (resp_valid),
   .resp_allow (resp_allow),
   .resp_code  (resp_code),
   .level_o    (level_o),
   .unlocked_o (unlocked_o)
);

// File: tb/cmd_access_guard_test.sv
module cmd_access_guard_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] prot_word = '0;
   logic        cmd_valid = 1'b0;
   logic [3:0]  cmd_code = '0;
   logic [31:0] cmd_addr = '0;
   logic [31:0] cmd_count = '0;
   logic [7:0]  sec_first = '0;
   logic [7:0]  sec_last = '0;
   logic        resp_valid, resp_allow, unlocked_o;
   logic [3:0]  resp_code;
   logic [2:0]  level_o;

   int vectors = 0;
   int miscompares = 0;
   bit model_open = 0;
   int unsigned seed_dummy;

   always #4 clk = ~clk;

   cmd_access_guard uut (
      .clk(clk), .rst_n(rst_n), .prot_word(prot_word),
      .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_addr(cmd_addr),
      .cmd_count(cmd_count), .sec_first(sec_first), .sec_last(sec_last),
      .resp_valid(resp_valid), .resp_allow(resp_allow), .resp_code(resp_code),
      .level_o(level_o), .unlocked_o(unlocked_o)
   );

   function automatic int exp_level(input logic [31:0] w);
      if (w == 32'h1234_5678) return 1;
      if (w == 32'h8765_4321) return 2;
      if (w == 32'h4321_8765) return 3;
      if (w == 32'h4E69_7370) return 4;
      return 0;
   endfunction

   function automatic int exp_code(input int lvl, input bit open, input int op,
                                   input logic [31:0] a, input logic [31:0] c,
                                   input int sf, input int sl);
      bit prot, fmt, secop, gated, full;
      full  = (sf == 0) && (sl == 63);
      fmt   = (op == 2) || (op == 3) || (op == 5) || (op == 8);
      secop = (op == 4) || (op == 6);
      gated = (op == 5) || (op == 6) || (op == 7);
      prot  = 0;
      if (op < 1 || op > 9) return 1;                       // R3
      if (lvl == 1)                                          // R4 R5
         prot = (op == 3) || (op == 8) || (op == 2 && a < 32'h1000_0600) ||
                (op == 5 && a < 32'd1024) || (op == 6 && sf == 0 && !full);
      if (lvl == 2)                                          // R6
         prot = (op == 2) || (op == 3) || (op == 5) || (op == 7) || (op == 8) ||
                (op == 6 && !full);
      if (prot) return 4;
      if (gated && !open) return 5;                          // R9
      if (fmt && a[1:0] != 0) return 2;                      // R8
      if (fmt && c[1:0] != 0) return 3;
      if (secop && (sf > sl || sl > 63)) return 6;           // R11
      if (op == 1 && a != 32'd23130) return 7;               // R10
      return 0;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int expv);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic do_reset(input logic [31:0] w);
      @(negedge clk);
      rst_n = 1'b0;
      cmd_valid = 1'b0;
      prot_word = w;
      repeat (3) @(negedge clk);
      check(resp_valid == 0 && unlocked_o == 0 && level_o == 0 && resp_code == 0,
            "R13 reset state", {resp_valid, unlocked_o, level_o}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      model_open = 0;
      check(int'(level_o) == exp_level(w), "R1 level decode", level_o, exp_level(w));
      check(unlocked_o == 0 && resp_valid == 0, "R13 after release", unlocked_o, 0);
   endtask

   task automatic send(input int op, input logic [31:0] a, input logic [31:0] c,
                       input int sf, input int sl, input string req);
      int e;
      int lvl;
      lvl = exp_level(prot_word);
      e = exp_code(lvl, model_open, op, a, c, sf, sl);
      cmd_valid = 1'b1;
      cmd_code  = 4'(op);
      cmd_addr  = a;
      cmd_count = c;
      sec_first = 8'(sf);
      sec_last  = 8'(sl);
      @(negedge clk);
      cmd_valid = 1'b0;
      check(resp_valid == 1, {req, " R2 strobe"}, resp_valid, 1);
      check(int'(resp_code) == e, req, resp_code, e);
      check(resp_allow == (e == 0), {req, " R2 allow"}, resp_allow, (e == 0));
      if (op == 1 && a == 32'd23130) model_open = 1;
      @(negedge clk);
      check(resp_valid == 0, "R2 single pulse", resp_valid, 0);
      check(unlocked_o == model_open, "R10 flag", unlocked_o, model_open);
   endtask

   function automatic logic [31:0] pick_addr();
      int s;
      s = $urandom_range(0, 5);
      case (s)
         0: return 32'h1000_0600 - 4 * $urandom_range(0, 3);
         1: return 32'h1000_0600 + 4 * $urandom_range(0, 3);
         2: return 4 * $urandom_range(0, 255);
         3: return 32'd1024 + 4 * $urandom_range(0, 1000);
         4: return $urandom;
         default: return 32'd23130;
      endcase
   endfunction

   function automatic int pick_sec();
      int s;
      s = $urandom_range(0, 3);
      if (s == 0) return 0;
      if (s == 1) return 63;
      if (s == 2) return $urandom_range(64, 70);
      return $urandom_range(1, 62);
   endfunction

   task automatic random_burst(input int n);
      for (int i = 0; i < n; i++) begin
         logic [31:0] c;
         c = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 99) : 4 * $urandom_range(0, 64);
         send($urandom_range(0, 15), pick_addr(), c, pick_sec(), pick_sec(), "R12 random mix");
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog R2 actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      seed_dummy = $urandom(32'd1234);

      // unprotected session with directed cases
      do_reset(32'h0000_0000);
      send(12, 0, 0, 0, 0, "R3 undefined code");
      send(6, 0, 0, 1, 2, "R9 erase before unlock");
      send(7, 0, 0, 0, 0, "R9 go before unlock");
      send(1, 32'd23131, 0, 0, 0, "R10 wrong key");
      send(1, 32'd23130, 0, 0, 0, "R10 good key");
      send(7, 0, 0, 0, 0, "R9 go after unlock");
      send(3, 32'h1000_0002, 8, 0, 0, "R8 misaligned address");
      send(3, 32'h1000_0002, 7, 0, 0, "R12 address before count");
      send(2, 32'h1000_0800, 6, 0, 0, "R8 count error");
      send(4, 0, 0, 5, 3, "R11 reversed range");
      send(4, 0, 0, 0, 64, "R11 past last sector");
      send(6, 0, 0, 0, 10, "R7 partial erase unprotected");
      random_burst(40);

      // level 1
      do_reset(32'h1234_5678);
      send(5, 32'd2048, 64, 0, 0, "R9 copy locked at level 1");
      send(1, 32'd23130, 0, 0, 0, "R10 unlock level 1");
      send(2, 32'h1000_05FC, 4, 0, 0, "R4 write below floor");
      send(2, 32'h1000_0600, 4, 0, 0, "R4 write at floor");
      send(3, 32'd0, 4, 0, 0, "R4 read denied");
      send(8, 32'd0, 4, 0, 0, "R4 compare denied");
      send(5, 32'd1020, 64, 0, 0, "R4 copy sector 0");
      send(5, 32'd1024, 64, 0, 0, "R4 copy sector 1");
      send(6, 0, 0, 0, 5, "R5 partial erase from 0");
      send(6, 0, 0, 0, 63, "R5 full erase");
      send(6, 0, 0, 2, 9, "R5 erase away from 0");
      send(5, 32'd1025, 64, 0, 0, "R8 copy misaligned");
      random_burst(40);
      prot_word = 32'h8765_4321;
      repeat (3) @(negedge clk);
      check(level_o == 3'd1, "R1 word ignored after latch", level_o, 1);
      prot_word = 32'h1234_5678;

      // level 2
      do_reset(32'h8765_4321);
      send(1, 32'd23130, 0, 0, 0, "R10 unlock level 2");
      send(7, 0, 0, 0, 0, "R6 go denied");
      send(2, 32'h1000_0800, 4, 0, 0, "R6 write denied");
      send(6, 0, 0, 1, 63, "R6 partial erase");
      send(6, 0, 0, 0, 63, "R6 full erase");
      send(4, 0, 0, 3, 4, "R6 prepare allowed");
      random_burst(40);

      // level 2 locked: protection outranks lock
      do_reset(32'h8765_4321);
      send(7, 0, 0, 0, 0, "R12 protection before lock");
      random_burst(20);

      // level 3 and no-entry
      do_reset(32'h4321_8765);
      send(3, 32'd0, 4, 0, 0, "R7 read at level 3");
      random_burst(30);
      do_reset(32'h4E69_7370);
      send(8, 32'd0, 4, 0, 0, "R7 compare no-entry");
      random_burst(30);

      // random protection words
      for (int k = 0; k < 3; k++) begin
         do_reset($urandom);
         random_burst(30);
      end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule